// File: doc/BRIEF.md
# Idle-Low Serial Clock SPI Master

This block is a single-word SPI master that runs from a fast system clock. A start strobe loads a parallel transmit word and the divider setting is captured at the same moment. The block pulls the active-low select line down, then produces a serial clock that idles low and toggles only while the word is moving. It drives the data-out line with an output enable and shifts the data-in line into a parallel receive word. When the word is complete it raises a one-cycle done pulse.

The serial clock period is set by an integer divider. A zero or odd divider gives equal high and low phases. A nonzero even divider gives a low phase that is two system cycles shorter than the high phase. The same low-phase width sets two gaps: the gap from select falling to the first rising clock edge, and the gap from the last falling clock edge to the release of the data line. Select goes high one system cycle after the data line is released. Data leaves on rising clock edges and is captured on falling edges, most significant bit first. The word width is a parameter from 8 to 32 bits.

Top module: `spi_cs_master`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, sclk_o is 0, ss_no is 1, mosi_oe_o is 0, busy_o is 0, done_o is 0 and rx_word_o is 0. A reset in the middle of a word returns all of these outputs to these values.
- R2: For a divider value d captured at start, the time between two successive rising edges of sclk_o is (1+d)*2 system cycles, and each high phase of sclk_o lasts that period minus the low-phase width of R3.
- R3: The low-phase width is (1+d) system cycles when d is zero or odd, and d system cycles when d is even and nonzero. Every low phase between two bits has this width.
- R4: ss_no falls one low-phase width before the first rising edge of sclk_o. sclk_o is high only while ss_no is low, and mosi_oe_o is low whenever ss_no is high.
- R5: mosi_o carries the transmit word most significant bit first. Bit k (counting from the MSB, k = 0) is valid from rising edge k+1 of sclk_o until rising edge k+2. mosi_o does not change while sclk_o is high. Exactly WORD_W rising edges occur per word.
- R6: mosi_oe_o rises together with the fall of ss_no, and mosi_o then already carries the MSB. Data-in is sampled on each falling edge of sclk_o, the first sample landing in the MSB. After done_o the value on rx_word_o equals the bits seen at the WORD_W falling edges.
- R7: mosi_oe_o falls one low-phase width after the last falling edge of sclk_o. ss_no rises exactly one system cycle later.
- R8: done_o is high for exactly one system cycle per word, in the cycle in which mosi_oe_o is first low. busy_o is high from the cycle after start is accepted through the done cycle, and low in the cycle after done.
- R9: A start_i pulse while busy_o is high is ignored. The current word continues with its original data and timing, and no second word follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| div_i | input | DIV_W | Clock divider setting, captured at start |
| tx_word_i | input | WORD_W | Transmit word, captured at start |
| rx_word_o | output | WORD_W | Received word, valid at done_o |
| done_o | output | 1 | One-cycle word-complete pulse |
| busy_o | output | 1 | Word in flight |
| sclk_o | output | 1 | Serial clock, idles low |
| ss_no | output | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Output enable for mosi_o (0 = high impedance) |
| miso_i | input | 1 | Serial data in |

## Verification
The hardest case to reach from the ports is the asymmetric clock produced by an even nonzero divider. This case needs a large divider value to show up clearly, and the high-versus-low split must be checked edge by edge over a whole word. The stimulus mixes directed words at divider values 0 through 4, 254 and 255 with random dividers. A monitor timestamps every select, clock and output-enable transition, so each phase width can be compared with the formula. Start pulses are also injected in the middle of a word and then compared with the data and timing of the word already in flight.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_END
  } spi_cs_state_e;
endpackage

// File: rtl/spi_cs_phase.sv
module spi_cs_phase #(
  parameter int DIV_W = 8,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic [DIV_W-1:0] div_i,
  output logic [CNT_W-1:0] lo_len_o,
  output logic [CNT_W-1:0] hi_len_o
);
  logic [CNT_W-1:0] div_ext;
  assign div_ext = {1'b0, div_i};

  // zero or odd divider: symmetric; even nonzero: low is div, high is div+2
  always_comb begin
    if (div_i[0] || div_i == '0) begin
      lo_len_o = div_ext + CNT_W'(1);
      hi_len_o = div_ext + CNT_W'(1);
    end else begin
      lo_len_o = div_ext;
      hi_len_o = div_ext + CNT_W'(2);
    end
  end
endmodule

// File: rtl/spi_cs_shift.sv
module spi_cs_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic [WORD_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)       tx_q <= tx_word_i;
      else if (shift_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      if (sample_i)     rx_q <= {rx_q[WORD_W-2:0], miso_i};
    end
  end

  assign mosi_o    = tx_q[WORD_W-1];
  assign rx_word_o = rx_q;
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8,
  localparam int CNT_W = DIV_W + 1,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] lo_len_i,
  input  logic [CNT_W-1:0] hi_len_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             sample_o,
  output logic             sclk_o,
  output logic             frame_o,
  output logic             oe_o,
  output logic             done_o
);
  spi_cs_state_e    state_q;
  logic [CNT_W-1:0] cnt_q, lo_q, hi_q;
  logic [BIT_W-1:0] bit_q;
  logic             lo_end, hi_end, last_bit;

  assign lo_end   = cnt_q == lo_q - CNT_W'(1);
  assign hi_end   = cnt_q == hi_q - CNT_W'(1);
  assign last_bit = bit_q == BIT_W'(WORD_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LEAD;
          cnt_q   <= '0;
          bit_q   <= '0;
          lo_q    <= lo_len_i;
          hi_q    <= hi_len_i;
        end
        ST_LEAD: if (lo_end) begin
          state_q <= ST_HIGH;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + CNT_W'(1);
        ST_HIGH: if (hi_end) begin
          cnt_q <= '0;
          if (last_bit) state_q <= ST_TAIL;
          else begin
            state_q <= ST_LOW;
            bit_q   <= bit_q + BIT_W'(1);
          end
        end else cnt_q <= cnt_q + CNT_W'(1);
        ST_LOW: if (lo_end) begin
          state_q <= ST_HIGH;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + CNT_W'(1);
        ST_TAIL: if (lo_end) state_q <= ST_END;
                 else cnt_q <= cnt_q + CNT_W'(1);
        ST_END:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o   = state_q == ST_IDLE && start_i;
  assign sample_o = state_q == ST_HIGH && hi_end;
  assign shift_o  = state_q == ST_LOW && lo_end;
  assign sclk_o   = state_q == ST_HIGH;
  assign frame_o  = state_q != ST_IDLE;
  assign oe_o     = frame_o && state_q != ST_END;
  assign done_o   = state_q == ST_END;
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              ss_no,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i
);
  localparam int CNT_W = DIV_W + 1;

  if (WORD_W < 8 || WORD_W > 32) begin : g_bad_width
    $error("WORD_W must be within 8..32");
  end

  logic [CNT_W-1:0] lo_len, hi_len;
  logic load, shift, sample, frame, oe, tx_bit;

  spi_cs_phase #(.DIV_W(DIV_W)) u_phase (
    .div_i    (div_i),
    .lo_len_o (lo_len),
    .hi_len_o (hi_len)
  );

  spi_cs_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .lo_len_i (lo_len),
    .hi_len_i (hi_len),
    .load_o   (load),
    .shift_o  (shift),
    .sample_o (sample),
    .sclk_o   (sclk_o),
    .frame_o  (frame),
    .oe_o     (oe),
    .done_o   (done_o)
  );

  spi_cs_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .tx_word_i (tx_word_i),
    .shift_i   (shift),
    .sample_i  (sample),
    .miso_i    (miso_i),
    .mosi_o    (tx_bit),
    .rx_word_o (rx_word_o)
  );

  // internal frame is active high; pin is active low
  assign ss_no     = ~frame;
  assign busy_o    = frame;
  assign mosi_oe_o = oe;
  assign mosi_o    = oe & tx_bit;
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic ss_no,
  input logic mosi_o,
  input logic mosi_oe_o,
  input logic done_o,
  input logic busy_o
);
  // R4
  sclk_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !ss_no);

  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_no |-> !sclk_o && !mosi_oe_o);

  // R5
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o && $past(sclk_o) |-> $stable(mosi_o));

  // R7
  release_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mosi_oe_o) |-> !ss_no && done_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
endmodule

bind spi_cs_master spi_cs_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sclk_o    (sclk_o),
  .ss_no     (ss_no),
  .mosi_o    (mosi_o),
  .mosi_oe_o (mosi_oe_o),
  .done_o    (done_o),
  .busy_o    (busy_o)
);

// File: tb/spi_cs_master_bench.sv
module spi_cs_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 16;
  localparam int DIV_W  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [DIV_W-1:0]  div_i = '0;
  logic [WORD_W-1:0] tx_word_i = '0;
  logic [WORD_W-1:0] rx_word_o;
  logic done_o, busy_o, sclk_o, ss_no, mosi_o, mosi_oe_o;
  logic miso_i = 1'b0;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cs_master #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_spi_cs_master (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .div_i(div_i),
    .tx_word_i(tx_word_i), .rx_word_o(rx_word_o), .done_o(done_o),
    .busy_o(busy_o), .sclk_o(sclk_o), .ss_no(ss_no), .mosi_o(mosi_o),
    .mosi_oe_o(mosi_oe_o), .miso_i(miso_i)
  );

  function automatic void chk(bit ok, string req, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  function automatic int exp_period(int d);
    return (1 + d) * 2;
  endfunction

  function automatic int exp_low(int d);
    if (d == 0 || (d % 2) == 1) return exp_period(d) / 2;
    return d;
  endfunction

  task automatic check_idle(string req);
    chk(sclk_o == 1'b0, req, sclk_o, 0);
    chk(ss_no == 1'b1, req, ss_no, 1);
    chk(mosi_oe_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, req,
        {mosi_oe_o, busy_o, done_o}, 0);
    chk(rx_word_o == '0, req, rx_word_o, 0);
  endtask

  task automatic run_frame(input logic [WORD_W-1:0] tx, input logic [WORD_W-1:0] srx,
                           input int dv, input bit inject);
    int t_r[WORD_W];
    int t_f[WORD_W];
    int nr = 0, nf = 0, cyc = 0, t_oef = -1, t_ssr = -1, ndone = 0, unstable = 0;
    int lo, per, bad_per = 0, bad_hi = 0, bad_lo = 0;
    bit fin = 0, busy_at_done = 0, oe_at_sel = 0;
    logic prev_sclk = 1'b0, prev_oe = 1'b1, prev_mosi = 1'b0;
    logic [WORD_W-1:0] cap = '0, rx_cap = '0;
    lo  = exp_low(dv);
    per = exp_period(dv);
    @(negedge clk);
    div_i = DIV_W'(dv); tx_word_i = tx; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; tx_word_i = ~tx;
    // R4: select low on the cycle after acceptance; R6: data already driven
    chk(ss_no == 1'b0 && busy_o == 1'b1, "R4", ss_no, 0);
    oe_at_sel = mosi_oe_o && (mosi_o == tx[WORD_W-1]);
    chk(oe_at_sel, "R6", mosi_o, tx[WORD_W-1]);
    miso_i = srx[WORD_W-1];
    while (!fin && cyc < 40000) begin
      if (sclk_o && !prev_sclk) begin
        if (nr < WORD_W) begin
          t_r[nr] = cyc;
          cap = {cap[WORD_W-2:0], mosi_o};
          if (nr >= 1) miso_i = srx[WORD_W-1-nr];
        end
        nr++;
      end
      if (!sclk_o && prev_sclk) begin
        if (nf < WORD_W) t_f[nf] = cyc;
        nf++;
      end
      if (sclk_o && prev_sclk && mosi_o != prev_mosi) unstable++;
      if (done_o) begin
        ndone++;
        rx_cap = rx_word_o;
        busy_at_done = busy_o;
      end
      if (!mosi_oe_o && prev_oe) t_oef = cyc;
      if (ss_no) begin
        t_ssr = cyc;
        fin = 1;
      end
      if (inject && cyc == 3) begin
        start_i = 1'b1; tx_word_i = WORD_W'($urandom);
      end else start_i = 1'b0;
      prev_sclk = sclk_o; prev_oe = mosi_oe_o; prev_mosi = mosi_o;
      if (!fin) begin
        @(negedge clk);
        cyc++;
      end
    end
    start_i = 1'b0;
    chk(nr == WORD_W && nf == WORD_W, "R5", nr, WORD_W);
    if (nr == WORD_W && nf == WORD_W) begin
      chk(t_r[0] == lo, "R4", t_r[0], lo);
      for (int i = 1; i < WORD_W; i++) if (t_r[i] - t_r[i-1] != per) bad_per++;
      for (int i = 0; i < WORD_W; i++) if (t_f[i] - t_r[i] != per - lo) bad_hi++;
      for (int i = 0; i < WORD_W - 1; i++) if (t_r[i+1] - t_f[i] != lo) bad_lo++;
      chk(bad_per == 0, "R2", bad_per, 0);
      chk(bad_hi == 0, "R2", bad_hi, 0);
      chk(bad_lo == 0, "R3", bad_lo, 0);
      chk(t_oef - t_f[WORD_W-1] == lo, "R7", t_oef - t_f[WORD_W-1], lo);
    end
    chk(t_ssr - t_oef == 1, "R7", t_ssr - t_oef, 1);
    chk(cap == tx, inject ? "R9" : "R5", cap, tx);
    chk(unstable == 0, "R5", unstable, 0);
    chk(rx_cap == srx, "R6", rx_cap, srx);
    chk(ndone == 1 && busy_at_done, "R8", ndone, 1);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R8", {busy_o, done_o}, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (inject) chk(ss_no == 1'b1 && sclk_o == 1'b0, "R9", ss_no, 1);
    end
  endtask

  initial begin
    void'($urandom(32'h1c5e_ed01));
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    check_idle("R1");

    // directed corners
    run_frame(16'hFFFF, 16'h0000, 0, 0);
    run_frame(16'h0000, 16'hFFFF, 1, 0);
    run_frame(16'hA5C3, 16'h5A3C, 2, 0);
    run_frame(16'h8001, 16'h7FFE, 3, 1);
    run_frame(16'h5555, 16'hAAAA, 4, 0);
    run_frame(16'h1234, 16'hFEDC, 254, 0);
    run_frame(16'hCAFE, 16'h0F0F, 255, 1);

    // random words and dividers, every fourth with a busy start
    for (int n = 0; n < 32; n++)
      run_frame(WORD_W'($urandom), WORD_W'($urandom), int'($urandom_range(0, 9)), (n % 4) == 0);

    // R1: reset in the middle of a word
    @(negedge clk);
    div_i = 8'd3; tx_word_i = 16'hFFFF; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (13) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check_idle("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    check_idle("R1");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule